// File: doc/BRIEF.md
# Interrupt Source Active-State Tracker

This block tracks the delivery state of a bank of physical interrupt sources inside an interrupt distributor. Each raw input line is either level or edge sensitive. For each source the block holds a pending bit and an active bit. It raises a registered request towards the CPU for the lowest-numbered source that is pending but not active, as long as no earlier acknowledge is still waiting for its end-of-interrupt.

The CPU side issues four commands, each as a valid strobe with a source index:
- **Acknowledge** moves a pending source to active and marks it in service.
- **End-of-interrupt** drops the in-service mark. In combined mode it also deactivates the source. In split mode the source stays active until a separate **deactivate** command arrives.
- **Set-active** lets software mark a source active without any acknowledge. A held level line then cannot interrupt the CPU again while a guest owns it.

A per-source no-active-state option serves message-style interrupts. Such sources are always edge sensitive, they return to inactive on acknowledge, and any deactivate aimed at them is ignored.

Top module: `irq_active_tracker`

## Requirements
- R1: `cpu_req` is a registered output. At clock edge k+1 it takes the value: some source was pending and not active after edge k, and no source was in service after edge k. `cpu_req_id` is then the lowest such index, and 0 when there is no request.
- R2: An acknowledge aimed at a source that is pending and not active sets the source's active bit and its in-service mark. For an edge source it also clears pending. An acknowledge aimed at a source that is not pending, or that is already active, changes nothing.
- R3: A set-active command sets the source's active bit whatever its pending state. It wins over a deactivate to the same source in the same cycle. It is ignored for no-active-state sources.
- R4: A level source (cfg_edge bit 0) has a pending bit equal to its line as sampled on the previous clock edge. After deactivation, a new request follows only if the line is still high.
- R5: An edge source (cfg_edge bit 1) becomes pending when its line is high in a cycle that follows a low cycle. Several such edges while the source is active leave a single pending bit. After deactivation, exactly one request follows.
- R6: If an edge arrives in the same cycle as a deactivate, the source ends inactive with pending set. If an edge arrives in the same cycle as an acknowledge, the source ends active with pending set.
- R7: With `split_mode` = 1, end-of-interrupt clears only the in-service mark, so other sources can be requested, and the deactivate command clears active. With `split_mode` = 0, end-of-interrupt also clears active.
- R8: While any source is in service, `cpu_req` stays low.
- R9: A source with its cfg_noact bit set behaves as edge sensitive whatever cfg_edge says. Acknowledge clears its pending bit and leaves it inactive. Neither an end-of-interrupt nor a deactivate changes its pending or active bit.
- R10: After reset all pending, active and in-service state is clear and `cpu_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_line | input | NUM_SRC | Raw interrupt lines |
| cfg_edge | input | NUM_SRC | 1 = edge sensitive, 0 = level sensitive |
| cfg_noact | input | NUM_SRC | 1 = source has no active state |
| split_mode | input | 1 | 1 = end-of-interrupt only drops priority |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Acknowledged source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Source for end-of-interrupt |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | ID_W | Source to deactivate |
| setact_valid | input | 1 | Software set-active strobe |
| setact_id | input | ID_W | Source to mark active |
| src_pend | output | NUM_SRC | Pending bits |
| src_act | output | NUM_SRC | Active bits |
| cpu_req | output | 1 | Registered request to the CPU |
| cpu_req_id | output | ID_W | Requested source index |

## Verification
A wrong pending or active bit shows on `src_pend` or `src_act` one clock after the command or line change that caused it. It reaches `cpu_req` and `cpu_req_id` one clock after that. A lost in-service mark shows as a request raised one cycle too early. A request that is lost or raised twice after deactivation shows within two cycles of the deactivate. Because every port is compared against a model on every clock, each such fault appears as a mismatch at most two edges after its cause.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

   // Per-source state: bit 0 = pending, bit 1 = active
   typedef enum logic [1:0] {
      ST_IDLE     = 2'b00,
      ST_PEND     = 2'b01,
      ST_ACT      = 2'b10,
      ST_PEND_ACT = 2'b11
   } src_state_e;

   function automatic logic st_pend(src_state_e s);
      return s[0];
   endfunction

   function automatic logic st_act(src_state_e s);
      return s[1];
   endfunction

   function automatic src_state_e st_make(logic pend, logic act);
      return src_state_e'({act, pend});
   endfunction

endpackage

// File: rtl/irq_line_front.sv
module irq_line_front #(
   parameter int NUM_SRC     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] raw_line,
   output logic [NUM_SRC-1:0] line_lvl,
   output logic [NUM_SRC-1:0] line_rise
);

   logic [NUM_SRC-1:0] lvl_q;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("irq_line_front: SYNC_STAGES must be 0..3");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign line_lvl = raw_line;
   end else begin : g_sync
      logic [NUM_SRC-1:0] chain_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) chain_q[s] <= '0;
         end else begin
            chain_q[0] <= raw_line;
            for (int s = 1; s < SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
         end
      end
      assign line_lvl = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= line_lvl;
   end

   assign line_rise = line_lvl & ~lvl_q;

endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode #(
   parameter int NUM_SRC = 32,
   parameter int ID_W    = 5
) (
   input  logic               cmd_valid,
   input  logic [ID_W-1:0]    cmd_id,
   output logic [NUM_SRC-1:0] cmd_hit
);

   if ((1 << ID_W) < NUM_SRC) begin : g_bad_w
      $error("irq_cmd_decode: ID_W too narrow for NUM_SRC");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      assign cmd_hit[i] = cmd_valid && (cmd_id == ID_W'(i));
   end

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import irq_trk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_lvl,
   input  logic line_rise,
   input  logic is_edge,
   input  logic no_act,
   input  logic ack_sel,
   input  logic deact_sel,
   input  logic set_sel,
   output logic pend,
   output logic act,
   output logic ack_taken
);

   src_state_e st_q;
   logic       pend_n, act_n, eff_edge, deact_ok, set_ok;

   assign pend      = st_pend(st_q);
   assign act       = st_act(st_q);
   assign eff_edge  = is_edge | no_act;
   assign ack_taken = ack_sel & pend & ~act;
   assign deact_ok  = deact_sel & ~no_act;
   assign set_ok    = set_sel & ~no_act;

   always_comb begin
      if (!eff_edge)      pend_n = line_lvl;
      else if (line_rise) pend_n = 1'b1;
      else if (ack_taken) pend_n = 1'b0;
      else                pend_n = pend;

      if (set_ok)                    act_n = 1'b1;
      else if (ack_taken && !no_act) act_n = 1'b1;
      else if (deact_ok)             act_n = 1'b0;
      else                           act_n = act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_make(pend_n, act_n);
   end

   // R2: accepted acknowledge leaves the source active
   a_r2_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_sel && pend && !act && !no_act) |=> act);

   // R3: set-active always lands
   a_r3_set_active: assert property (@(posedge clk) disable iff (!rst_n)
      (set_sel && !no_act) |=> act);

   // R5: edge while active is remembered as pending
   a_r5_edge_while_active: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_edge && line_rise && act) |=> pend);

   // R6: edge racing a deactivate ends inactive and pending
   a_r6_edge_with_deact: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_edge && line_rise && deact_sel && !set_sel && !no_act) |=> (pend && !act));

   // R9: a no-active-state source never becomes active
   a_r9_noact_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (no_act && !act) |=> !act);

endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
   parameter int NUM_SRC = 32,
   parameter int ID_W    = 5
) (
   input  logic [NUM_SRC-1:0] cand,
   output logic               found,
   output logic [ID_W-1:0]    idx
);

   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand[i]) idx = ID_W'(i);
      end
      found = |cand;
   end

   // R1: the chosen index is always a real candidate
   always_comb begin
      if (found) begin
         a_r1_pick_valid: assert (cand[idx]);
      end
   end

endmodule

// File: rtl/irq_active_tracker.sv
module irq_active_tracker #(
   parameter int NUM_SRC     = 32,
   parameter int SYNC_STAGES = 0,
   localparam int ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_line,
   input  logic [NUM_SRC-1:0] cfg_edge,
   input  logic [NUM_SRC-1:0] cfg_noact,
   input  logic               split_mode,
   input  logic               ack_valid,
   input  logic [ID_W-1:0]    ack_id,
   input  logic               eoi_valid,
   input  logic [ID_W-1:0]    eoi_id,
   input  logic               deact_valid,
   input  logic [ID_W-1:0]    deact_id,
   input  logic               setact_valid,
   input  logic [ID_W-1:0]    setact_id,
   output logic [NUM_SRC-1:0] src_pend,
   output logic [NUM_SRC-1:0] src_act,
   output logic               cpu_req,
   output logic [ID_W-1:0]    cpu_req_id
);

   if (NUM_SRC < 2 || NUM_SRC > 1024) begin : g_bad_n
      $error("irq_active_tracker: NUM_SRC must be 2..1024");
   end

   logic [NUM_SRC-1:0] lvl, rise;
   logic [NUM_SRC-1:0] ack_hit, eoi_hit, deact_hit, set_hit;
   logic [NUM_SRC-1:0] deact_sel, ack_taken, inserv_q, cand;
   logic               pick_found;
   logic [ID_W-1:0]    pick_idx;

   irq_line_front #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .raw_line(src_line),
      .line_lvl(lvl), .line_rise(rise));

   irq_cmd_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_dec_ack (
      .cmd_valid(ack_valid), .cmd_id(ack_id), .cmd_hit(ack_hit));
   irq_cmd_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_dec_eoi (
      .cmd_valid(eoi_valid), .cmd_id(eoi_id), .cmd_hit(eoi_hit));
   irq_cmd_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_dec_deact (
      .cmd_valid(deact_valid), .cmd_id(deact_id), .cmd_hit(deact_hit));
   irq_cmd_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_dec_set (
      .cmd_valid(setact_valid), .cmd_id(setact_id), .cmd_hit(set_hit));

   // combined mode: end-of-interrupt doubles as deactivate
   assign deact_sel = deact_hit | (eoi_hit & {NUM_SRC{~split_mode}});

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      irq_src_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .line_lvl(lvl[i]), .line_rise(rise[i]),
         .is_edge(cfg_edge[i]), .no_act(cfg_noact[i]),
         .ack_sel(ack_hit[i]), .deact_sel(deact_sel[i]), .set_sel(set_hit[i]),
         .pend(src_pend[i]), .act(src_act[i]), .ack_taken(ack_taken[i]));

      // R1: a source active over two edges is never the request
      a_r1_active_not_requested: assert property (@(posedge clk) disable iff (!rst_n)
         (src_act[i] && $past(src_act[i])) |-> !(cpu_req && cpu_req_id == ID_W'(i)));

      // R7: split mode end-of-interrupt leaves the source active
      a_r7_split_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
         (split_mode && eoi_hit[i] && !deact_hit[i] && src_act[i]) |=> src_act[i]);

      // R7: combined mode end-of-interrupt deactivates
      a_r7_combined_deacts: assert property (@(posedge clk) disable iff (!rst_n)
         (!split_mode && eoi_hit[i] && !set_hit[i] && !cfg_noact[i]) |=> !src_act[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inserv_q <= '0;
      else        inserv_q <= (inserv_q & ~eoi_hit) | ack_taken;
   end

   assign cand = src_pend & ~src_act;

   irq_pick_lowest #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
      .cand(cand), .found(pick_found), .idx(pick_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_req    <= 1'b0;
         cpu_req_id <= '0;
      end else begin
         cpu_req    <= pick_found && (inserv_q == '0);
         cpu_req_id <= (pick_found && (inserv_q == '0)) ? pick_idx : '0;
      end
   end

   // R8: an outstanding acknowledge blocks the next request
   a_r8_inservice_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (inserv_q != '0) |=> !cpu_req);

endmodule

// File: tb/irq_active_tracker_test.sv
module irq_active_tracker_test;
   localparam int N = 32;
   localparam int W = 5;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] src_line = '0, cfg_edge = '0, cfg_noact = '0;
   logic split_mode = 1'b0;
   logic ack_valid = 0, eoi_valid = 0, deact_valid = 0, setact_valid = 0;
   logic [W-1:0] ack_id = '0, eoi_id = '0, deact_id = '0, setact_id = '0;
   logic [N-1:0] src_pend, src_act;
   logic cpu_req;
   logic [W-1:0] cpu_req_id;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_active_tracker #(.NUM_SRC(N)) uut (
      .clk(clk), .rst_n(rst_n), .src_line(src_line), .cfg_edge(cfg_edge),
      .cfg_noact(cfg_noact), .split_mode(split_mode),
      .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
      .deact_valid(deact_valid), .deact_id(deact_id),
      .setact_valid(setact_valid), .setact_id(setact_id),
      .src_pend(src_pend), .src_act(src_act), .cpu_req(cpu_req), .cpu_req_id(cpu_req_id));

   // behavioural reference model
   bit mp[N], ma[N], mi[N], mlq[N];
   bit mreq;
   int mid;

   always @(posedge clk) begin : model
      bit np[N], na[N], ni[N];
      bit any_in;
      int first;
      if (!rst_n) begin
         foreach (mp[i]) begin mp[i] = 0; ma[i] = 0; mi[i] = 0; mlq[i] = 0; end
         mreq = 0; mid = 0;
      end else begin
         any_in = 0; first = -1;
         foreach (mp[i]) begin
            if (mi[i]) any_in = 1;
            if (first < 0 && mp[i] && !ma[i]) first = i;
         end
         foreach (mp[i]) begin
            bit edg, noa, rise, ackh, deh, seth;
            noa  = cfg_noact[i];
            edg  = cfg_edge[i] || noa;
            rise = src_line[i] && !mlq[i];
            ackh = ack_valid && ack_id == W'(i) && mp[i] && !ma[i];
            deh  = !noa && ((deact_valid && deact_id == W'(i)) ||
                            (!split_mode && eoi_valid && eoi_id == W'(i)));
            seth = !noa && setact_valid && setact_id == W'(i);
            np[i] = !edg ? src_line[i] : rise ? 1'b1 : ackh ? 1'b0 : mp[i];
            na[i] = seth ? 1'b1 : (ackh && !noa) ? 1'b1 : deh ? 1'b0 : ma[i];
            ni[i] = ackh ? 1'b1 : (eoi_valid && eoi_id == W'(i)) ? 1'b0 : mi[i];
         end
         mreq = (first >= 0) && !any_in;
         mid  = mreq ? first : 0;
         foreach (mp[i]) begin
            mp[i] = np[i]; ma[i] = na[i]; mi[i] = ni[i]; mlq[i] = src_line[i];
         end
      end
   end

   task automatic fail_line(string tag, int act_v, int exp_v);
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         foreach (mp[i]) begin
            n_chk++;
            if (src_pend[i] !== mp[i]) fail_line($sformatf("R4 R5 pend[%0d]", i), src_pend[i], mp[i]);
            n_chk++;
            if (src_act[i] !== ma[i]) fail_line($sformatf("R2 R3 act[%0d]", i), src_act[i], ma[i]);
         end
         n_chk++;
         if (cpu_req !== mreq) fail_line("R1 cpu_req", cpu_req, mreq);
         if (mreq) begin
            n_chk++;
            if (int'(cpu_req_id) != mid) fail_line("R1 cpu_req_id", cpu_req_id, mid);
         end
      end
   end

   task automatic chk(string tag, int act_v, int exp_v);
      n_chk++;
      if (act_v != exp_v) fail_line(tag, act_v, exp_v);
   endtask

   task automatic cyc(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_ack(int id);
      ack_id = W'(id); ack_valid = 1; cyc(); ack_valid = 0;
   endtask
   task automatic do_eoi(int id);
      eoi_id = W'(id); eoi_valid = 1; cyc(); eoi_valid = 0;
   endtask
   task automatic do_deact(int id);
      deact_id = W'(id); deact_valid = 1; cyc(); deact_valid = 0;
   endtask
   task automatic do_set(int id);
      setact_id = W'(id); setact_valid = 1; cyc(); setact_valid = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      fail_line("watchdog", 0, 1);
      finish_run();
   end

   initial begin
      cfg_edge[5] = 1; cfg_edge[7] = 1; cfg_noact[12] = 1;
      cyc(3);
      chk("R10 cpu_req after reset", cpu_req, 0);
      chk("R10 pend after reset", int'(src_pend != 0), 0);
      rst_n = 1;
      cyc();
      chk("R10 act after reset", int'(src_act != 0), 0);

      // R2: acknowledge of an idle source is ignored
      do_ack(20);
      chk("R2 ignored ack", src_act[20], 0);

      // level source 3, combined mode
      src_line[3] = 1; cyc();
      chk("R4 level pend", src_pend[3], 1);
      cyc();
      chk("R1 req", cpu_req, 1); chk("R1 req id", cpu_req_id, 3);
      do_ack(3);
      chk("R2 ack active", src_act[3], 1);
      cyc();
      chk("R8 req low in service", cpu_req, 0);
      do_eoi(3);
      chk("R7 combined eoi deact", src_act[3], 0);
      cyc();
      chk("R4 line held re-request", cpu_req, 1); chk("R4 id", cpu_req_id, 3);
      do_ack(3);
      src_line[3] = 0;
      do_eoi(3);
      chk("R4 pend after release", src_pend[3], 0);
      cyc();
      chk("R4 no re-request", cpu_req, 0);

      // edge sources, split mode
      split_mode = 1;
      src_line[5] = 1; cyc(); src_line[5] = 0;
      chk("R5 edge pend", src_pend[5], 1);
      cyc();
      chk("R1 req id 5", cpu_req_id, 5);
      do_ack(5);
      chk("R2 edge ack clears pend", src_pend[5], 0);
      for (int k = 0; k < 3; k++) begin
         src_line[5] = 1; cyc(); src_line[5] = 0; cyc();
      end
      chk("R5 collapsed pend", src_pend[5], 1); chk("R5 still active", src_act[5], 1);
      src_line[7] = 1; cyc(); src_line[7] = 0; cyc();
      chk("R8 blocked by in-service", cpu_req, 0);
      do_eoi(5);
      chk("R7 split eoi keeps active", src_act[5], 1);
      cyc();
      chk("R7 other source taken", cpu_req_id, 7); chk("R7 req", cpu_req, 1);
      do_deact(5);
      chk("R7 deact clears", src_act[5], 0);
      cyc();
      chk("R5 one request after deact", cpu_req_id, 5);
      do_ack(5); do_eoi(5); do_deact(5);
      chk("R5 no second pend", src_pend[5], 0);
      cyc();
      chk("R5 exactly once", cpu_req_id, 7);
      do_ack(7); do_eoi(7); do_deact(7);
      cyc(2);
      chk("R1 idle", cpu_req, 0);

      // R6: edge racing acknowledge, then deactivate
      src_line[5] = 1; cyc(); src_line[5] = 0; cyc();
      src_line[5] = 1; ack_id = 5; ack_valid = 1; cyc(); ack_valid = 0; src_line[5] = 0;
      chk("R6 edge with ack pend", src_pend[5], 1); chk("R6 edge with ack act", src_act[5], 1);
      do_eoi(5);
      src_line[5] = 1; deact_id = 5; deact_valid = 1; cyc(); deact_valid = 0; src_line[5] = 0;
      chk("R6 edge with deact pend", src_pend[5], 1); chk("R6 edge with deact act", src_act[5], 0);
      cyc();
      chk("R6 request", cpu_req_id, 5);
      do_ack(5); do_eoi(5); do_deact(5);

      // R3: software set-active on level source 9
      src_line[9] = 1; do_set(9);
      chk("R3 set active", src_act[9], 1); chk("R3 pend", src_pend[9], 1);
      cyc(2);
      chk("R3 no request", cpu_req, 0);
      setact_id = 9; setact_valid = 1; deact_id = 9; deact_valid = 1; cyc();
      setact_valid = 0; deact_valid = 0;
      chk("R3 wins over deact", src_act[9], 1);
      do_deact(9);
      cyc();
      chk("R4 held line after deact", cpu_req_id, 9);
      src_line[9] = 0; cyc(2);
      chk("R4 released", cpu_req, 0);

      // R9: no-active-state source 12
      split_mode = 0;
      src_line[12] = 1; cyc();
      chk("R9 pend", src_pend[12], 1);
      cyc();
      chk("R9 req id", cpu_req_id, 12);
      do_ack(12);
      chk("R9 ack no active", src_act[12], 0); chk("R9 ack clears pend", src_pend[12], 0);
      cyc(2);
      chk("R9 held line no re-pend", src_pend[12], 0);
      do_set(12);
      chk("R9 set ignored", src_act[12], 0);
      do_eoi(12);
      chk("R9 linked deact ignored", src_act[12] + src_pend[12], 0);
      do_deact(12);
      chk("R9 deact ignored", src_act[12] + src_pend[12], 0);
      src_line[12] = 0;
      cyc(3);
      finish_run();
   end
endmodule